// File: doc/BRIEF.md
# Multi-Lane Serial Register Port

This block is the slave side of a serial control port. A host reaches a small internal register file through it. Every cycle opens with an instruction byte that names a register and a direction. A data phase follows, and its length equals the width of the addressed register. When the last data bit has moved, the next bits on the lines form a fresh instruction byte. No gap or deselect is needed between cycles.

A configuration register at address 0 chooses how the port works. Its lane field selects one of four modes: one lane on a shared pin, one lane with a separate output pin, two lanes, or four lanes. Its order bit selects whether a word, including the instruction byte, is sent top bit first or bit 0 first.

Two rules protect a cycle. Raising chip select pauses a cycle and does not cancel it. In the modes with fewer than four lanes, a high level on data pin 3 cancels the cycle, and no register changes. The block runs directly on the serial clock, with an asynchronous active-low reset. The pads are modelled as separate input, output and output-enable vectors.

Top module: `serreg_port`

## Requirements
- R1: After reset, every register reads zero, so the port is in single-lane shared-pin mode with top-bit-first order, and no output enable is set.
- R2: Instruction bit 7 set selects a read and clear selects a write. Instruction bits 4..0 give the register address.
- R3: The data phase lasts exactly the addressed register's width: 8 bits at address 0, 24 at 1, 16 at 2, and 32 at every other address. The bits after it are taken as a new instruction byte.
- R4: Register 0 bit 0 clear sends words top bit first, and set sends bit 0 first. The instruction byte and multi-byte data both follow this order.
- R5: Register 0 bits 2..1 select the lane mode. 00 is one lane on pin 0, 01 is one lane in on pin 0 with read data out on pin 2, 10 is two lanes on pins 0 and 1, and 11 is four lanes on pins 0 to 3. Pin 0 carries the earliest bit of each group, and the later bits go on the higher pins in turn.
- R6: During the read data phase, each group of read bits is driven after a falling clock edge. The output enables are set only on that mode's data pins, and only while chip select is low.
- R7: While chip select is high, all output enables are clear and the cycle is frozen. It resumes at the same bit when chip select returns low.
- R8: In modes 00, 01 and 10, a high level on pin 3 at a rising edge cancels the cycle and holds the port at the start of an instruction until the pin falls. This works even while chip select is high. In mode 11, pin 3 is an ordinary data lane.
- R9: Written data is stored only after the final data bit, so a cancelled write changes nothing. New mode and order settings apply from the next instruction byte.
- R10: Addresses 6 to 31 read as zero, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock. Inputs are captured on its rising edge, and read data is launched on its falling edge. |
| rstN | input | 1 | Asynchronous active-low reset. |
| csN | input | 1 | Active-low chip select. |
| sdioIn | input | 4 | Levels seen on the four data pads. Pin 3 also serves as the cancel input. |
| sdioOut | output | 4 | Values driven onto the data pads. |
| sdioOe | output | 4 | Per-pad output enables. A clear bit leaves the pad at high impedance. |

## Verification
On every cycle, the assertions check four things. Deselect leaves the pads released and the bit position frozen. A cancel returns the port to the start of an instruction. The count of enabled pads matches the lane count of the active mode. The mode field changes only on a cycle boundary.

Only the bench's scenarios can show the rest. These cover the bit-exact word contents under each order and lane mode, and the width-dependent phase lengths. They also cover the discarded writes to unmapped addresses and a cancelled write leaving its register intact. Finally, they check that a new mode takes hold on the very next instruction. For this, the bench compares each pad group against its own model of the register file.

// File: rtl/serreg_pkg.sv
`timescale 1ns/1ps
package serreg_pkg;
  localparam int ADDR_W   = 5;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 6;
  localparam int LANES    = 4;
  localparam int INSTR_W  = 8;
  localparam int POS_W    = $clog2(WORD_W) + 1;
  localparam int BIT_W    = $clog2(WORD_W);
  localparam int IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [1:0] {
    MODE_SHARED = 2'b00,
    MODE_SPLIT  = 2'b01,
    MODE_DUAL   = 2'b10,
    MODE_QUAD   = 2'b11
  } laneMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             step;
    logic             syncOn;
    logic             inData;
    logic             lastGroup;
    logic [POS_W-1:0] seqPos;
    logic [2:0]       laneCnt;
  } ctrlStb_t;

  function automatic logic [POS_W-1:0] regWidth(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0:    return POS_W'(8);
      5'd1:    return POS_W'(24);
      5'd2:    return POS_W'(16);
      default: return POS_W'(WORD_W);
    endcase
  endfunction

  // sequence position -> bit index inside a word of width w
  function automatic logic [BIT_W-1:0] bitIdx(input logic [POS_W-1:0] pos,
                                               input logic [POS_W-1:0] w,
                                               input logic lsbFirst);
    return lsbFirst ? pos[BIT_W-1:0] : BIT_W'(w - pos - POS_W'(1));
  endfunction
endpackage

// File: rtl/serreg_ctrl.sv
`timescale 1ns/1ps
module serreg_ctrl
  import serreg_pkg::*;
(
  input  logic             sclk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             syncPin,
  input  laneMode_t        mode,
  input  logic [POS_W-1:0] dataWidth,
  output ctrlStb_t         stb
);
  logic             inData;
  logic [POS_W-1:0] seqPos;
  logic [2:0]       laneCnt;
  logic [POS_W-1:0] phaseWidth;
  logic             syncOn, step, lastGroup;

  always_comb begin
    unique case (mode)
      MODE_DUAL: laneCnt = 3'd2;
      MODE_QUAD: laneCnt = 3'd4;
      default:   laneCnt = 3'd1;
    endcase
  end

  assign syncOn     = syncPin && (mode != MODE_QUAD);
  assign step       = !csN && !syncOn;
  assign phaseWidth = inData ? dataWidth : POS_W'(INSTR_W);
  assign lastGroup  = (seqPos + POS_W'(laneCnt)) == phaseWidth;

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      inData <= 1'b0;
      seqPos <= '0;
    end else if (syncOn) begin
      inData <= 1'b0;
      seqPos <= '0;
    end else if (step) begin
      if (lastGroup) begin
        inData <= !inData;
        seqPos <= '0;
      end else begin
        seqPos <= seqPos + POS_W'(laneCnt);
      end
    end
  end

  assign stb = '{step: step, syncOn: syncOn, inData: inData,
                 lastGroup: lastGroup, seqPos: seqPos, laneCnt: laneCnt};
endmodule

// File: rtl/serreg_dp.sv
`timescale 1ns/1ps
module serreg_dp
  import serreg_pkg::*;
(
  input  logic             sclk,
  input  logic             rstN,
  input  logic             csN,
  input  logic [LANES-1:0] sdioIn,
  input  ctrlStb_t         stb,
  output laneMode_t        mode,
  output logic [POS_W-1:0] dataWidth,
  output logic [LANES-1:0] sdioOut,
  output logic [LANES-1:0] sdioOe
);
  logic [WORD_W-1:0]  regBank [NUM_REGS];
  logic [INSTR_W-1:0] instrReg, nextInstr;
  logic [WORD_W-1:0]  shadowReg, nextShadow, readWord, widthMask;
  logic [LANES-1:0]   laneOn, laneRd, laneRdReg, laneMask;
  logic [POS_W-1:0]   lanePos [LANES];
  logic [BIT_W-1:0]   laneIdx [LANES];
  logic [POS_W-1:0]   phaseWidth;
  logic [ADDR_W-1:0]  addr;
  logic               isRead, lsbFirst, mapped, commit;
  logic               unusedInstr;

  assign addr        = instrReg[ADDR_W-1:0];
  assign isRead      = instrReg[INSTR_W-1];
  assign unusedInstr = ^instrReg[INSTR_W-2:ADDR_W];
  assign mode        = laneMode_t'(regBank[0][2:1]);
  assign lsbFirst    = regBank[0][0];
  assign dataWidth   = regWidth(addr);
  assign mapped      = addr < ADDR_W'(NUM_REGS);
  assign readWord    = mapped ? regBank[addr[IDX_W-1:0]] : '0;
  assign widthMask   = (dataWidth == POS_W'(WORD_W)) ? '1
                     : ((WORD_W'(1) << dataWidth) - WORD_W'(1));
  assign phaseWidth  = stb.inData ? dataWidth : POS_W'(INSTR_W);
  assign commit      = stb.step && stb.inData && stb.lastGroup && !isRead && mapped;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneOn[k]  = 3'(k) < stb.laneCnt;
    assign lanePos[k] = stb.seqPos + POS_W'(k);
    assign laneIdx[k] = bitIdx(lanePos[k], phaseWidth, lsbFirst);
    assign laneRd[k]  = laneOn[k] && readWord[laneIdx[k]];
  end

  always_comb begin
    nextInstr  = instrReg;
    nextShadow = shadowReg;
    for (int k = 0; k < LANES; k++) begin
      if (laneOn[k]) begin
        if (stb.inData) nextShadow[laneIdx[k]] = sdioIn[k];
        else            nextInstr[laneIdx[k][2:0]] = sdioIn[k];
      end
    end
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      instrReg  <= '0;
      shadowReg <= '0;
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= '0;
    end else if (stb.step) begin
      if (stb.inData) shadowReg <= nextShadow;
      else            instrReg  <= nextInstr;
      if (commit) regBank[addr[IDX_W-1:0]] <= nextShadow & widthMask;
    end
  end

  // read bits launched on the falling edge
  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN) laneRdReg <= '0;
    else       laneRdReg <= laneRd;
  end

  always_comb begin
    unique case (mode)
      MODE_SHARED: laneMask = 4'b0001;
      MODE_SPLIT:  laneMask = 4'b0100;
      MODE_DUAL:   laneMask = 4'b0011;
      default:     laneMask = 4'b1111;
    endcase
  end

  assign sdioOut = (mode == MODE_SPLIT) ? {1'b0, laneRdReg[0], 2'b00} : laneRdReg;
  assign sdioOe  = (stb.inData && isRead && !csN) ? laneMask : '0;
endmodule

// File: rtl/serreg_port.sv
`timescale 1ns/1ps
module serreg_port
  import serreg_pkg::*;
(
  input  logic       sclk,
  input  logic       rstN,
  input  logic       csN,
  input  logic [3:0] sdioIn,
  output logic [3:0] sdioOut,
  output logic [3:0] sdioOe
);
  ctrlStb_t         stb;
  laneMode_t        mode;
  logic [POS_W-1:0] dataWidth;

  serreg_ctrl u_ctrl (
    .sclk(sclk), .rstN(rstN), .csN(csN), .syncPin(sdioIn[3]),
    .mode(mode), .dataWidth(dataWidth), .stb(stb)
  );

  serreg_dp u_dp (
    .sclk(sclk), .rstN(rstN), .csN(csN), .sdioIn(sdioIn), .stb(stb),
    .mode(mode), .dataWidth(dataWidth), .sdioOut(sdioOut), .sdioOe(sdioOe)
  );
endmodule

// File: rtl/serreg_checker.sv
`timescale 1ns/1ps
module serreg_checker
  import serreg_pkg::*;
(
  input logic       sclk,
  input logic       rstN,
  input logic       csN,
  input logic [3:0] sdioOe,
  input ctrlStb_t   stb,
  input laneMode_t  mode
);
  a_r7_released_when_deselected: assert property (@(posedge sclk) disable iff (!rstN)
    csN |-> (sdioOe == 4'b0000));

  a_r7_frozen_when_deselected: assert property (@(posedge sclk) disable iff (!rstN)
    (csN && !stb.syncOn) |=> ($stable(stb.seqPos) && $stable(stb.inData)));

  a_r8_cancel_restarts: assert property (@(posedge sclk) disable iff (!rstN)
    stb.syncOn |=> ((stb.seqPos == '0) && !stb.inData));

  a_r6_enables_match_lanes: assert property (@(posedge sclk) disable iff (!rstN)
    (sdioOe != 4'b0000) |-> ($countones(sdioOe) == int'(stb.laneCnt)));

  a_r6_enables_only_in_data: assert property (@(posedge sclk) disable iff (!rstN)
    (sdioOe != 4'b0000) |-> stb.inData);

  a_r9_mode_changes_at_boundary: assert property (@(posedge sclk) disable iff (!rstN)
    !$stable(mode) |-> ((stb.seqPos == '0) && !stb.inData));

  a_r3_instr_position_bound: assert property (@(posedge sclk) disable iff (!rstN)
    !stb.inData |-> (stb.seqPos < POS_W'(INSTR_W)));
endmodule

bind serreg_port serreg_checker u_chk (
  .sclk(sclk), .rstN(rstN), .csN(csN), .sdioOe(sdioOe), .stb(stb), .mode(mode)
);

// File: tb/serreg_port_test.sv
`timescale 1ns/1ps
module serreg_port_test;
  logic       sclk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN  = 1'b1;
  logic [3:0] sdioIn = 4'b0000;
  logic [3:0] sdioOut, sdioOe;
  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  // behavioural model of the register file and settings
  longint mReg [0:31];
  int     mMode = 0;
  bit     mLsb  = 0;

  always #2.5 sclk = ~sclk;

  serreg_port uut (.sclk(sclk), .rstN(rstN), .csN(csN),
                   .sdioIn(sdioIn), .sdioOut(sdioOut), .sdioOe(sdioOe));

  function automatic int widthOf(input int a);
    if (a == 0) return 8;
    if (a == 1) return 24;
    if (a == 2) return 16;
    return 32;
  endfunction

  function automatic int lanesOf(input int m);
    if (m == 2) return 2;
    if (m == 3) return 4;
    return 1;
  endfunction

  function automatic logic [3:0] maskOf(input int m);
    case (m)
      0: return 4'b0001;
      1: return 4'b0100;
      2: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: drive after the falling edge, compare before the rising edge
  task automatic stepEdge(input logic [3:0] pins, input logic cs,
                          input logic [3:0] expOe, input logic [3:0] expOut,
                          input string req);
    @(negedge sclk);
    #1;
    sdioIn = pins;
    csN    = cs;
    #0.5;
    check(sdioOe === expOe, req, "output enable", sdioOe, expOe);
    if (expOe != 4'b0000)
      check((sdioOut & expOe) === (expOut & expOe), req, "read lanes",
            sdioOut & expOe, expOut & expOe);
  endtask

  task automatic idle(input int n);
    repeat (n) stepEdge(4'b0000, 1'b1, 4'b0000, 4'b0000, "R7 idle");
  endtask

  // full cycle; suspendAt / abortAt give a group index, or -1 for none
  task automatic transact(input bit rd, input int addr, input longint data,
                          input int suspendAt, input int abortAt,
                          input string req);
    int n = lanesOf(mMode);
    int w = widthOf(addr);
    bit seqBits[$];
    logic [7:0] ins;
    longint expWord;
    longint got = 0;
    ins = {rd, 2'b00, addr[4:0]};
    expWord = (addr <= 5) ? mReg[addr] : 0;
    for (int i = 0; i < 8; i++) seqBits.push_back(mLsb ? ins[i] : ins[7-i]);
    for (int i = 0; i < w; i++) begin
      int b = mLsb ? i : (w - 1 - i);
      seqBits.push_back(rd ? expWord[b] : data[b]);
    end
    for (int g = 0; g < (8 + w) / n; g++) begin
      bit rdPh = rd && (g * n >= 8);
      logic [3:0] pins = 4'b0000;
      logic [3:0] expOut = 4'b0000;
      if (g == abortAt) begin
        // R8: pin 3 high cancels; the cycle restarts after it falls
        stepEdge(4'b1000, 1'b0, 4'b0000, 4'b0000, "R8 cancel");
        stepEdge(4'b1000, 1'b0, 4'b0000, 4'b0000, "R8 cancel");
        stepEdge(4'b0000, 1'b1, 4'b0000, 4'b0000, "R8 cancel");
        return;
      end
      if (g == suspendAt)
        repeat (3) stepEdge(4'b0000, 1'b1, 4'b0000, 4'b0000, "R7 suspend");
      for (int k = 0; k < n; k++) begin
        if (rdPh) expOut[(mMode == 1) ? 2 : k] = seqBits[g*n + k];
        else      pins[k] = seqBits[g*n + k];
      end
      stepEdge(pins, 1'b0, rdPh ? maskOf(mMode) : 4'b0000, expOut, req);
      if (rdPh) begin
        for (int k = 0; k < n; k++) begin
          int idx = g*n + k - 8;
          int b = mLsb ? idx : (w - 1 - idx);
          got[b] = sdioOut[(mMode == 1) ? 2 : k];
        end
      end
    end
    if (rd) begin
      check(got == expWord, req, $sformatf("read word @%0d", addr), got, expWord);
    end else if (addr <= 5) begin
      mReg[addr] = data & ((longint'(1) << w) - 1);
      if (addr == 0) begin
        mMode = int'((mReg[0] >> 1) & 3);
        mLsb  = mReg[0][0];
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge sclk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mReg[i] = 0;
    repeat (3) @(negedge sclk);
    check(sdioOe === 4'b0000, "R1", "enable in reset", sdioOe, 0);
    rstN = 1'b1;
    idle(2);

    // R1 reset contents, R2/R3 basic cycles in shared single-lane mode
    transact(1, 0, 0, -1, -1, "R1 reset cfg");
    transact(1, 1, 0, -1, -1, "R1 reset reg");
    transact(0, 1, 64'hA5C37E, -1, -1, "R2 write");
    transact(1, 1, 0, -1, -1, "R2 R3 24-bit");
    transact(0, 2, 64'hBEEF, -1, -1, "R3 write");
    transact(0, 3, 64'h12345678, -1, -1, "R3 write");
    transact(0, 5, 64'hCAFEF00D, -1, -1, "R3 write");
    transact(1, 2, 0, -1, -1, "R3 16-bit");
    transact(1, 3, 0, -1, -1, "R3 32-bit");
    idle(1);
    // R10 unmapped address
    transact(0, 9, 64'hFFFFFFFF, -1, -1, "R10 write");
    transact(1, 9, 0, -1, -1, "R10 reads zero");
    transact(1, 5, 0, -1, -1, "R10 neighbour intact");
    // R7 suspend in write and in read
    transact(0, 4, 64'h0F0F1234, 13, -1, "R7 write");
    transact(1, 4, 0, 20, -1, "R7 resumed read");
    // R8/R9 cancelled write leaves register
    transact(0, 3, 64'hDEADBEEF, -1, 15, "R8 cancel");
    transact(1, 3, 0, -1, -1, "R9 cancelled write");
    transact(1, 2, 0, -1, 5, "R8 cancel read instr");
    transact(1, 2, 0, -1, -1, "R8 after cancel");
    // R4/R9 switch to bit-0-first, used by the next instruction at once
    transact(0, 0, 64'h01, -1, -1, "R4 cfg");
    transact(1, 1, 0, -1, -1, "R4 R9 lsb read");
    transact(0, 2, 64'h8001, -1, -1, "R4 lsb write");
    transact(1, 2, 0, -1, -1, "R4 lsb read");
    // R5/R6 split pin mode
    transact(0, 0, 64'h03, -1, -1, "R5 cfg split");
    transact(1, 3, 0, -1, -1, "R5 R6 split read");
    transact(0, 4, 64'h89ABCDEF, -1, -1, "R5 split write");
    transact(1, 4, 0, 4, -1, "R6 split read");
    // dual lanes, top bit first
    transact(0, 0, 64'h04, -1, -1, "R5 cfg dual");
    transact(0, 1, 64'h3C5A69, -1, -1, "R5 dual write");
    transact(1, 1, 0, -1, -1, "R5 R6 dual read");
    transact(0, 1, 64'h000001, -1, 9, "R8 dual cancel");
    transact(1, 1, 0, -1, -1, "R9 dual unchanged");
    // quad lanes: pin 3 is data, not cancel
    transact(0, 0, 64'h07, -1, -1, "R5 cfg quad lsb");
    transact(0, 3, 64'hFFFFFFFF, -1, -1, "R8 quad ones");
    transact(1, 3, 0, -1, -1, "R8 quad no cancel");
    transact(0, 0, 64'h06, -1, -1, "R5 cfg quad msb");
    transact(1, 0, 0, -1, -1, "R9 cfg readback");
    transact(1, 5, 0, 3, -1, "R5 R6 quad read");
    transact(0, 0, 64'h00, -1, -1, "R9 back to default");
    transact(1, 2, 0, -1, -1, "R9 default read");
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule